// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block stores the per-interrupt state of a multi-processor interrupt controller and lets software read and change it through a small register bus. It keeps three bit arrays (enable, pending, active), one priority byte and one CPU-target byte per interrupt, two-bit trigger configuration fields, a distributor-wide enable and a read-only type word. Every stored bit is also driven out on plain output ports, so that the arbitration and acknowledge logic elsewhere can read it directly.

The first 32 interrupts are private: their enable, pending, active and priority state is kept in a separate bank for each CPU. The bank used is the one of the CPU that issues the request. Each bit array is reached through two windows that share one storage. A write to the set window ORs the data into the array. A write to the clear window clears every bit that is 1 in the data. A read of either window returns the current state.

Requests use a valid/ready handshake and responses use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and stays unchanged until `rsp_ready` is sampled high. `req_ready` is high when no response is held or when the held response is taken in the same cycle, so back-to-back accesses run at one per cycle.

Top module: `gicd_regbank`

Address map (byte offsets, 11-bit address). Word n of a bit array covers interrupts 32n to 32n+31, with bit b holding interrupt 32n+b:

| Offset | Register |
|---|---|
| 0x000 | control, bit 0 = distributor enable |
| 0x008 | type word, read-only |
| 0x100 / 0x140 | enable set / enable clear words |
| 0x180 / 0x1C0 | pending set / pending clear words |
| 0x200 / 0x240 | active set / active clear words |
| 0x280 | trigger configuration words |
| 0x400 + n | priority byte of interrupt n |
| 0x600 + n | target byte of interrupt n |

## Requirements
- R1: A request is accepted on an edge where `req_valid` and `req_ready` are both high, and its response is valid on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response data and the error bit hold steady and `req_ready` is low.
- R2: After reset, every stored bit is zero and no response is pending. This means disabled, not pending, inactive, priority 0, target 0 and configuration 0.
- R3: Enable words (size 4, word-aligned) at 0x100+4n and 0x140+4n share one array. Set ORs the data into it, clear does an AND-NOT with the data, and a read of either window returns the state.
- R4: Pending (0x180/0x1C0) and active (0x200/0x240) words follow the same set/clear pairing as enable, with OR on set and AND-NOT on clear.
- R5: On writes to pending word 0 through either window, data bits 15:0 have no effect. These are the software-generated interrupts. Active word 0 has no such mask.
- R6: Word 0 of the three bit arrays and the priority bytes of interrupts 0 to 31 are banked per CPU, selected by `req_cpu`. On the ports, CPU c's bank sits at bits c*32+b (arrays) and c*256+8b (priority).
- R7: The priority byte of interrupt n is at 0x400+n and may be accessed with size 1, 2 or 4 at any alignment. Interrupt n occupies data bits 7:0 and interrupt n+k occupies bits 8k+7:8k. On the ports, interrupt n≥32 sits at bits 8(n-32) of `prio_shr`.
- R8: The target byte of interrupt n≥32 is at 0x600+n, with size 1 or 4. A size-4 access rounds n down to a multiple of 4 and covers four interrupts, packed as in R7. Size 2 is an error.
- R9: A target read of any interrupt 0 to 31 returns the one-hot mask (1 << `req_cpu`) in every byte lane of the access. Writes to those targets change nothing.
- R10: The type word reads ((NUM_CPUS-1) << 5) | (NUM_IRQ/32 - 1). Writes to it are accepted without error and have no effect.
- R11: The control word stores data bit 0 as the distributor enable, drives it on `dist_enable`, and reads it back in bit 0.
- R12: There are 2*NUM_IRQ/32 full 32-bit trigger configuration words at 0x280+4n, readable and writable with size 4.
- R13: Each accepted error-free write to a pending, priority or target register produces a one-cycle `reeval_pulse` in the cycle its response becomes valid.
- R14: Each of the following is an error: an unmapped offset, a size other than 1, 2 or 4, a word register accessed with size other than 4 or misaligned, or an index past the implemented interrupts. An error sets `rsp_err`, returns zero data and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte offset |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_cpu | input | CPU_W | Index of requesting CPU |
| req_wdata | input | 32 | Write data, byte lanes from bit 0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (zero on writes and errors) |
| rsp_err | output | 1 | Access error |
| dist_enable | output | 1 | Distributor enable |
| en_priv | output | NUM_CPUS*32 | Banked enable bits of interrupts 0-31 |
| en_shr | output | NUM_IRQ-32 | Enable bits of interrupts 32 and up |
| pend_priv | output | NUM_CPUS*32 | Banked pending bits |
| pend_shr | output | NUM_IRQ-32 | Shared pending bits |
| act_priv | output | NUM_CPUS*32 | Banked active bits |
| act_shr | output | NUM_IRQ-32 | Shared active bits |
| prio_priv | output | NUM_CPUS*256 | Banked priority bytes |
| prio_shr | output | (NUM_IRQ-32)*8 | Shared priority bytes |
| tgt_priv | output | NUM_CPUS*256 | Fixed one-hot targets of private interrupts |
| tgt_shr | output | (NUM_IRQ-32)*8 | Target bytes of interrupts 32 and up |
| trig_cfg | output | NUM_IRQ/16*32 | Trigger configuration words |
| reeval_pulse | output | 1 | Request to re-evaluate the highest pending interrupt |

## Verification
Two things can happen in the same cycle: a held response is released and the next request is accepted, and that request is a pending write that also raises the re-evaluation pulse. The bench provokes this by holding `rsp_ready` low after a read while a pending-set write waits at the input. It checks that the read data stays steady and that the write does not take effect early. It then raises `rsp_ready` and checks that, on the next cycle, the write's response, its `reeval_pulse` and the new pending bit appear together.

// File: rtl/gicd_pkg.sv
package gicd_pkg;
  localparam int ADDR_W   = 11;
  localparam int PRIV_IRQ = 32;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE,
    RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR, RG_AC_SET, RG_AC_CLR,
    RG_CFG, RG_PRIO, RG_TGT
  } region_e;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 11'h000;
  localparam logic [ADDR_W-1:0] OFF_TYPE = 11'h008;
endpackage

// File: rtl/gicd_decode.sv
module gicd_decode
  import gicd_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output region_e           region,
  output logic [8:0]        idx,
  output logic              err
);
  localparam int NUM_GRP = NUM_IRQ / 32;
  localparam int NUM_CFG = 2 * NUM_GRP;

  logic size_ok, word_ok, fit;
  logic [9:0] span_end;

  always_comb begin
    size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    word_ok  = (size == 3'd4) && (addr[1:0] == 2'b00);
    span_end = {1'b0, addr[8:0]} + {7'd0, size};
    region   = RG_NONE;
    idx      = '0;
    fit      = 1'b0;
    case (addr[10:6])
      5'd0: begin
        if (addr == OFF_CTRL) region = RG_CTRL;
        else if (addr == OFF_TYPE) region = RG_TYPE;
        fit = word_ok;
      end
      5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9: begin
        region = region_e'(4'(int'(RG_EN_SET) + int'(addr[10:6]) - 4));
        idx    = {5'd0, addr[5:2]};
        fit    = word_ok && (int'(addr[5:2]) < NUM_GRP);
      end
      5'd10, 5'd11: begin
        region = RG_CFG;
        idx    = {4'd0, addr[6:2]};
        fit    = word_ok && (int'(addr[6:2]) < NUM_CFG);
      end
      5'd16, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23: begin
        region = RG_PRIO;
        idx    = addr[8:0];
        fit    = int'(span_end) <= NUM_IRQ;
      end
      5'd24, 5'd25, 5'd26, 5'd27, 5'd28, 5'd29, 5'd30, 5'd31: begin
        region = RG_TGT;
        idx    = (size == 3'd4) ? {addr[8:2], 2'b00} : addr[8:0];
        fit    = ((size == 3'd1) || (size == 3'd4)) && (int'(addr[8:0]) < NUM_IRQ);
      end
      default: region = RG_NONE;
    endcase
    err = !size_ok || (region == RG_NONE) || !fit;
  end
endmodule

// File: rtl/gicd_bitarray.sv
module gicd_bitarray #(
  parameter int          NUM_CPUS  = 4,
  parameter int          NUM_GRP   = 2,
  parameter int          CPU_W     = 2,
  parameter logic [31:0] LOCK_MASK = 32'h0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic                     clr_en,
  input  logic [3:0]               word_idx,
  input  logic [CPU_W-1:0]         cpu,
  input  logic [31:0]              wdata,
  output logic [31:0]              rd_word,
  output logic [NUM_CPUS*32-1:0]   priv_q,
  output logic [(NUM_GRP-1)*32-1:0] shr_q
);
  logic [31:0] priv_r [NUM_CPUS];
  logic [31:0] shr_r  [NUM_GRP-1];
  logic [31:0] eff;

  assign eff = (word_idx == 4'd0) ? (wdata & ~LOCK_MASK) : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPUS; c++) priv_r[c] <= '0;
      for (int g = 0; g < NUM_GRP-1; g++) shr_r[g] <= '0;
    end else begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (word_idx == 4'd0 && cpu == CPU_W'(c)) begin
          if (set_en)      priv_r[c] <= priv_r[c] | eff;
          else if (clr_en) priv_r[c] <= priv_r[c] & ~eff;
        end
      end
      for (int g = 1; g < NUM_GRP; g++) begin
        if (word_idx == 4'(g)) begin
          if (set_en)      shr_r[g-1] <= shr_r[g-1] | eff;
          else if (clr_en) shr_r[g-1] <= shr_r[g-1] & ~eff;
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (word_idx == 4'd0 && cpu == CPU_W'(c)) rd_word = priv_r[c];
    for (int g = 1; g < NUM_GRP; g++)
      if (word_idx == 4'(g)) rd_word = shr_r[g-1];
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_priv
    assign priv_q[c*32 +: 32] = priv_r[c];

    // R3 R4
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && word_idx == 4'd0 && cpu == CPU_W'(c)) |=>
        ((priv_r[c] & $past(eff)) == $past(eff)));

    // R3 R4
    clr_andnot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en && word_idx == 4'd0 && cpu == CPU_W'(c)) |=>
        ((priv_r[c] & $past(eff)) == 32'd0));

    // R5
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en || clr_en) |=>
        ((priv_r[c] & LOCK_MASK) == ($past(priv_r[c]) & LOCK_MASK)));
  end

  for (genvar g = 1; g < NUM_GRP; g++) begin : g_shr
    assign shr_q[(g-1)*32 +: 32] = shr_r[g-1];
  end
endmodule

// File: rtl/gicd_bytearray.sv
module gicd_bytearray #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQ  = 64,
  parameter int CPU_W    = 2,
  parameter bit BANKED   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [8:0]                  base,
  input  logic [2:0]                  nbytes,
  input  logic [CPU_W-1:0]            cpu,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rd_data,
  output logic [NUM_CPUS*256-1:0]     priv_q,
  output logic [(NUM_IRQ-32)*8-1:0]   shr_q
);
  localparam int NSHR = NUM_IRQ - 32;

  logic [7:0] shr_r  [NSHR];
  logic [7:0] priv_v [NUM_CPUS][32];
  logic [9:0] lane_irq [4];

  always_comb
    for (int k = 0; k < 4; k++) lane_irq[k] = {1'b0, base} + 10'(k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NSHR; j++) shr_r[j] <= '0;
    end else if (wr_en) begin
      for (int j = 0; j < NSHR; j++)
        for (int k = 0; k < 4; k++)
          if (3'(k) < nbytes && lane_irq[k] == 10'(j + 32))
            shr_r[j] <= wdata[8*k +: 8];
    end
  end

  if (BANKED) begin : g_banked
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < NUM_CPUS; c++)
          for (int i = 0; i < 32; i++) priv_v[c][i] <= '0;
      end else if (wr_en) begin
        for (int c = 0; c < NUM_CPUS; c++)
          for (int i = 0; i < 32; i++)
            for (int k = 0; k < 4; k++)
              if (cpu == CPU_W'(c) && 3'(k) < nbytes && lane_irq[k] == 10'(i))
                priv_v[c][i] <= wdata[8*k +: 8];
      end
    end
  end else begin : g_fixed
    always_comb
      for (int c = 0; c < NUM_CPUS; c++)
        for (int i = 0; i < 32; i++) priv_v[c][i] = 8'(1 << c);
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < nbytes) begin
        for (int c = 0; c < NUM_CPUS; c++)
          for (int i = 0; i < 32; i++)
            if (cpu == CPU_W'(c) && lane_irq[k] == 10'(i))
              rd_data[8*k +: 8] = priv_v[c][i];
        for (int j = 0; j < NSHR; j++)
          if (lane_irq[k] == 10'(j + 32)) rd_data[8*k +: 8] = shr_r[j];
      end
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_pq
    for (genvar i = 0; i < 32; i++) begin : g_pi
      assign priv_q[(c*32 + i)*8 +: 8] = priv_v[c][i];
    end
  end
  for (genvar j = 0; j < NSHR; j++) begin : g_sq
    assign shr_q[j*8 +: 8] = shr_r[j];
  end

  // R7 R8
  lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(base) >= 32 && int'(base) < NUM_IRQ) |=>
      (shr_q[(int'($past(base)) - 32)*8 +: 8] == $past(wdata[7:0])));
endmodule

// File: rtl/gicd_regbank.sv
module gicd_regbank
  import gicd_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQ  = 64,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int NUM_GRP = NUM_IRQ / 32,
  localparam int NUM_CFG = 2 * NUM_GRP,
  localparam int NSHR    = NUM_IRQ - 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [2:0]              req_size,
  input  logic [CPU_W-1:0]        req_cpu,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_rdata,
  output logic                    rsp_err,
  output logic                    dist_enable,
  output logic [NUM_CPUS*32-1:0]  en_priv,
  output logic [NSHR-1:0]         en_shr,
  output logic [NUM_CPUS*32-1:0]  pend_priv,
  output logic [NSHR-1:0]         pend_shr,
  output logic [NUM_CPUS*32-1:0]  act_priv,
  output logic [NSHR-1:0]         act_shr,
  output logic [NUM_CPUS*256-1:0] prio_priv,
  output logic [NSHR*8-1:0]       prio_shr,
  output logic [NUM_CPUS*256-1:0] tgt_priv,
  output logic [NSHR*8-1:0]       tgt_shr,
  output logic [NUM_CFG*32-1:0]   trig_cfg,
  output logic                    reeval_pulse
);
  localparam logic [31:0] TYPE_VAL = (32'(NUM_CPUS - 1) << 5) | 32'(NUM_GRP - 1);

  region_e     region;
  logic [8:0]  idx;
  logic        dec_err, accept, wr;
  logic [31:0] rd_mux, prio_rd, tgt_rd;
  logic [31:0] ba_rd   [3];
  logic [NUM_CPUS*32-1:0] ba_priv [3];
  logic [NSHR-1:0]        ba_shr  [3];
  logic [31:0] cfg_r [NUM_CFG];
  logic        en_r, reeval_q;

  gicd_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr(req_addr), .size(req_size), .region(region), .idx(idx), .err(dec_err)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr        = accept && req_write && !dec_err;

  for (genvar b = 0; b < 3; b++) begin : g_bits
    localparam region_e SET_R = region_e'(4'(int'(RG_EN_SET) + 2*b));
    localparam region_e CLR_R = region_e'(4'(int'(RG_EN_SET) + 2*b + 1));
    gicd_bitarray #(
      .NUM_CPUS(NUM_CPUS), .NUM_GRP(NUM_GRP), .CPU_W(CPU_W),
      .LOCK_MASK((b == 1) ? 32'h0000_FFFF : 32'h0)
    ) u_bits (
      .clk(clk), .rst_n(rst_n),
      .set_en(wr && region == SET_R), .clr_en(wr && region == CLR_R),
      .word_idx(idx[3:0]), .cpu(req_cpu), .wdata(req_wdata),
      .rd_word(ba_rd[b]), .priv_q(ba_priv[b]), .shr_q(ba_shr[b])
    );
  end

  gicd_bytearray #(.NUM_CPUS(NUM_CPUS), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .BANKED(1'b1)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && region == RG_PRIO), .base(idx),
    .nbytes(req_size), .cpu(req_cpu), .wdata(req_wdata), .rd_data(prio_rd),
    .priv_q(prio_priv), .shr_q(prio_shr)
  );

  gicd_bytearray #(.NUM_CPUS(NUM_CPUS), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .BANKED(1'b0)) u_tgt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && region == RG_TGT), .base(idx),
    .nbytes(req_size), .cpu(req_cpu), .wdata(req_wdata), .rd_data(tgt_rd),
    .priv_q(tgt_priv), .shr_q(tgt_shr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= 1'b0;
      for (int n = 0; n < NUM_CFG; n++) cfg_r[n] <= '0;
    end else if (wr) begin
      if (region == RG_CTRL) en_r <= req_wdata[0];
      for (int n = 0; n < NUM_CFG; n++)
        if (region == RG_CFG && idx == 9'(n)) cfg_r[n] <= req_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (region)
      RG_CTRL:              rd_mux = {31'd0, en_r};
      RG_TYPE:              rd_mux = TYPE_VAL;
      RG_EN_SET, RG_EN_CLR: rd_mux = ba_rd[0];
      RG_PD_SET, RG_PD_CLR: rd_mux = ba_rd[1];
      RG_AC_SET, RG_AC_CLR: rd_mux = ba_rd[2];
      RG_CFG:
        for (int n = 0; n < NUM_CFG; n++)
          if (idx == 9'(n)) rd_mux = cfg_r[n];
      RG_PRIO:              rd_mux = prio_rd;
      RG_TGT:               rd_mux = tgt_rd;
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      reeval_q  <= 1'b0;
    end else begin
      reeval_q <= wr && (region == RG_PD_SET || region == RG_PD_CLR ||
                         region == RG_PRIO   || region == RG_TGT);
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_err   <= dec_err;
        rsp_rdata <= (dec_err || req_write) ? 32'd0 : rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign dist_enable  = en_r;
  assign reeval_pulse = reeval_q;
  assign en_priv   = ba_priv[0];
  assign en_shr    = ba_shr[0];
  assign pend_priv = ba_priv[1];
  assign pend_shr  = ba_shr[1];
  assign act_priv  = ba_priv[2];
  assign act_shr   = ba_shr[2];
  for (genvar n = 0; n < NUM_CFG; n++) begin : g_cfg
    assign trig_cfg[n*32 +: 32] = cfg_r[n];
  end

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R1
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R14
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));

  // R14
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4)) |=> rsp_err);

  // R13
  reeval_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reeval_pulse |-> (rsp_valid && !rsp_err));

  // R11
  ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == RG_CTRL) |=> (dist_enable == $past(req_wdata[0])));
endmodule

// File: tb/gicd_regbank_tb.sv
module gicd_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int NIRQ = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [10:0] req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [1:0]  req_cpu = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, dist_enable, reeval_pulse;
  logic [31:0] rsp_rdata;
  logic [NCPU*32-1:0] en_priv, pend_priv, act_priv;
  logic [NIRQ-33:0] en_shr, pend_shr, act_shr;
  logic [NCPU*256-1:0] prio_priv, tgt_priv;
  logic [(NIRQ-32)*8-1:0] prio_shr, tgt_shr;
  logic [NIRQ/16*32-1:0] trig_cfg;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gicd_regbank #(.NUM_CPUS(NCPU), .NUM_IRQ(NIRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_cpu(req_cpu), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dist_enable(dist_enable), .en_priv(en_priv), .en_shr(en_shr),
    .pend_priv(pend_priv), .pend_shr(pend_shr), .act_priv(act_priv),
    .act_shr(act_shr), .prio_priv(prio_priv), .prio_shr(prio_shr),
    .tgt_priv(tgt_priv), .tgt_shr(tgt_shr), .trig_cfg(trig_cfg),
    .reeval_pulse(reeval_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [10:0] a, input logic [2:0] sz,
                     input logic [1:0] cpu, input logic [31:0] d,
                     output logic [31:0] rd, output logic er, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz;
    req_cpu = cpu; req_wdata = d; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err; rv = reeval_pulse;
  endtask

  task automatic wr(input string tag, input logic [10:0] a, input logic [2:0] sz,
                    input logic [1:0] cpu, input logic [31:0] d, input logic exp_rv);
    logic [31:0] rd; logic er, rv;
    acc(1'b1, a, sz, cpu, d, rd, er, rv);
    check({tag, " wr err"}, 32'(er), 32'd0);
    check({tag, " R13 pulse"}, 32'(rv), 32'(exp_rv));
  endtask

  task automatic rdchk(input string tag, input logic [10:0] a, input logic [2:0] sz,
                       input logic [1:0] cpu, input logic [31:0] exp);
    logic [31:0] rd; logic er, rv;
    acc(1'b0, a, sz, cpu, 32'd0, rd, er, rv);
    check({tag, " err"}, 32'(er), 32'd0);
    check(tag, rd, exp);
  endtask

  task automatic errchk(input string tag, input bit w, input logic [10:0] a,
                        input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] rd; logic er, rv;
    acc(w, a, sz, 2'd0, d, rd, er, rv);
    check({tag, " R14 err"}, 32'(er), 32'd1);
    check({tag, " R14 data"}, rd, 32'd0);
  endtask

  task automatic t_reset();
    check("R2 rsp_valid", 32'(rsp_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    check("R2 dist_enable", 32'(dist_enable), 0);
    check("R2 en", 32'(|{en_priv, en_shr, pend_priv, pend_shr, act_priv, act_shr}), 0);
    check("R2 bytes", 32'(|{prio_priv, prio_shr, tgt_shr, trig_cfg}), 0);
  endtask

  task automatic t_type_ctrl();
    rdchk("R10 type", 11'h008, 3'd4, 2'd0, 32'h61);
    wr("R10 type write", 11'h008, 3'd4, 2'd1, 32'hFFFF_FFFF, 1'b0);
    rdchk("R10 type after write", 11'h008, 3'd4, 2'd0, 32'h61);
    wr("R11 ctrl", 11'h000, 3'd4, 2'd0, 32'h1, 1'b0);
    check("R11 dist_enable on", 32'(dist_enable), 1);
    rdchk("R11 ctrl read", 11'h000, 3'd4, 2'd3, 32'h1);
    wr("R11 ctrl off", 11'h000, 3'd4, 2'd0, 32'h0, 1'b0);
    check("R11 dist_enable off", 32'(dist_enable), 0);
  endtask

  task automatic t_enable();
    wr("R3 set a", 11'h104, 3'd4, 2'd0, 32'h0000_00F0, 1'b0);
    wr("R3 set b", 11'h104, 3'd4, 2'd2, 32'h0F00_0000, 1'b0);
    rdchk("R3 read clr alias", 11'h144, 3'd4, 2'd1, 32'h0F00_00F0);
    wr("R3 clr", 11'h144, 3'd4, 2'd0, 32'h0000_0030, 1'b0);
    rdchk("R3 read set alias", 11'h104, 3'd4, 2'd0, 32'h0F00_00C0);
    check("R3 en_shr port", en_shr, 32'h0F00_00C0);
    wr("R6 bank cpu1", 11'h100, 3'd4, 2'd1, 32'h5, 1'b0);
    rdchk("R6 cpu2 bank empty", 11'h100, 3'd4, 2'd2, 32'h0);
    rdchk("R6 cpu1 bank", 11'h140, 3'd4, 2'd1, 32'h5);
    check("R6 en_priv port", en_priv[32 +: 32], 32'h5);
  endtask

  task automatic t_pend_act();
    wr("R5 pend set w0", 11'h180, 3'd4, 2'd0, 32'hFFFF_FFFF, 1'b1);
    rdchk("R5 pend w0 masked", 11'h180, 3'd4, 2'd0, 32'hFFFF_0000);
    check("R5 pend_priv port", pend_priv[31:0], 32'hFFFF_0000);
    wr("R5 pend clr w0", 11'h1C0, 3'd4, 2'd0, 32'hF0F0_FFFF, 1'b1);
    rdchk("R5 pend after clr", 11'h1C0, 3'd4, 2'd0, 32'h0F0F_0000);
    wr("R4 pend set w1", 11'h184, 3'd4, 2'd3, 32'h0000_00A5, 1'b1);
    wr("R4 pend clr w1", 11'h1C4, 3'd4, 2'd3, 32'h0000_0005, 1'b1);
    check("R4 pend_shr", pend_shr, 32'h0000_00A0);
    wr("R4 act set w1", 11'h204, 3'd4, 2'd0, 32'h3, 1'b0);
    wr("R4 act clr w1", 11'h244, 3'd4, 2'd0, 32'h1, 1'b0);
    rdchk("R4 act w1", 11'h204, 3'd4, 2'd0, 32'h2);
    wr("R5 act w0 unmasked", 11'h200, 3'd4, 2'd2, 32'h0000_FFFF, 1'b0);
    check("R5 act_priv cpu2", act_priv[64 +: 32], 32'h0000_FFFF);
  endtask

  task automatic t_prio();
    wr("R7 prio w4", 11'h400 + 11'd40, 3'd4, 2'd0, 32'h4433_2211, 1'b1);
    check("R7 prio port 40..43", prio_shr[8*8 +: 32], 32'h4433_2211);
    rdchk("R7 prio byte 42", 11'h400 + 11'd42, 3'd1, 2'd0, 32'h33);
    rdchk("R7 prio half 41", 11'h400 + 11'd41, 3'd2, 2'd0, 32'h3322);
    wr("R7 prio half 45", 11'h400 + 11'd45, 3'd2, 2'd0, 32'hBBAA, 1'b1);
    rdchk("R7 prio unaligned 44", 11'h400 + 11'd44, 3'd4, 2'd0, 32'h00BB_AA00);
    wr("R6 prio cpu3 irq5", 11'h400 + 11'd5, 3'd1, 2'd3, 32'h7E, 1'b1);
    rdchk("R6 prio cpu0 irq5", 11'h400 + 11'd5, 3'd1, 2'd0, 32'h0);
    rdchk("R6 prio cpu3 irq5", 11'h400 + 11'd5, 3'd1, 2'd3, 32'h7E);
    check("R6 prio_priv port", 32'(prio_priv[(3*32+5)*8 +: 8]), 32'h7E);
    wr("R7 prio span", 11'h400 + 11'd30, 3'd4, 2'd1, 32'hD4C3_B2A1, 1'b1);
    rdchk("R7 span cpu1", 11'h400 + 11'd30, 3'd4, 2'd1, 32'hD4C3_B2A1);
    rdchk("R6 span cpu2", 11'h400 + 11'd30, 3'd4, 2'd2, 32'hD4C3_0000);
  endtask

  task automatic t_target();
    wr("R8 tgt w4 rounded", 11'h600 + 11'd34, 3'd4, 2'd0, 32'h0804_0201, 1'b1);
    check("R8 tgt port 32..35", tgt_shr[31:0], 32'h0804_0201);
    rdchk("R8 tgt byte 35", 11'h600 + 11'd35, 3'd1, 2'd0, 32'h08);
    wr("R8 tgt byte 50", 11'h600 + 11'd50, 3'd1, 2'd0, 32'h0C, 1'b1);
    check("R8 tgt port 50", 32'(tgt_shr[18*8 +: 8]), 32'h0C);
    errchk("R8 tgt size2", 1'b0, 11'h600 + 11'd40, 3'd2, 32'd0);
    rdchk("R9 priv tgt cpu2", 11'h600, 3'd4, 2'd2, 32'h0404_0404);
    rdchk("R9 priv tgt cpu0 b7", 11'h600 + 11'd7, 3'd1, 2'd0, 32'h01);
    wr("R9 priv tgt write", 11'h600 + 11'd3, 3'd1, 2'd2, 32'hFF, 1'b1);
    rdchk("R9 priv tgt unchanged", 11'h600, 3'd4, 2'd2, 32'h0404_0404);
    check("R9 tgt_priv port", 32'(tgt_priv[(1*32+9)*8 +: 8]), 32'h02);
  endtask

  task automatic t_cfg_err();
    wr("R12 cfg w3", 11'h28C, 3'd4, 2'd1, 32'hDEAD_BEEF, 1'b0);
    rdchk("R12 cfg read", 11'h28C, 3'd4, 2'd0, 32'hDEAD_BEEF);
    check("R12 cfg port", trig_cfg[96 +: 32], 32'hDEAD_BEEF);
    errchk("cfg past end", 1'b0, 11'h290, 3'd4, 32'd0);
    errchk("unmapped", 1'b0, 11'h010, 3'd4, 32'd0);
    errchk("size3", 1'b0, 11'h000, 3'd3, 32'd0);
    errchk("enable idx2", 1'b0, 11'h108, 3'd4, 32'd0);
    errchk("word size1", 1'b0, 11'h100, 3'd1, 32'd0);
    errchk("prio overrun", 1'b0, 11'h400 + 11'd62, 3'd4, 32'd0);
    errchk("en set size2", 1'b1, 11'h104, 3'd2, 32'h0000_FFFF);
    check("R14 no state change", en_shr, 32'h0F00_00C0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h008; req_size = 3'd4; req_cpu = 2'd0;
    @(posedge clk);
    @(negedge clk);
    check("R1 rsp valid", 32'(rsp_valid), 1);
    check("R1 rsp data", rsp_rdata, 32'h61);
    req_write = 1'b1; req_addr = 11'h184; req_wdata = 32'h100;
    check("R1 ready low", 32'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R1 rsp held", rsp_rdata, 32'h61);
    check("R1 write not early", pend_shr, 32'h0000_00A0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 next rsp", 32'(rsp_valid && !rsp_err && rsp_rdata == 0), 1);
    check("R13 pulse with rsp", 32'(reeval_pulse), 1);
    check("R4 pend applied", pend_shr, 32'h0000_01A0);
    @(negedge clk);
    check("R13 pulse one cycle", 32'(reeval_pulse), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_type_ctrl();
    t_enable();
    t_pend_act();
    t_prio();
    t_target();
    t_cfg_err();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule